// File: doc/BRIEF.md
# Paired Pulse Count and Timestamp Capture

This block turns a wheel-speed pulse train into a pair of numbers from which a host can work out speed. It counts the falling edges on an asynchronous pulse input and records the value of a free-running timebase at the moment of each counted pulse. The timebase advances once every `DIVIDE` system clocks and wraps at its width.

A one-cycle read strobe copies the live pulse count and the latest pulse timestamp together into a pair of holding registers. It then clears the live count. The host therefore always sees a count together with the time of the last pulse inside that count. If the pulses stop partway through an interval, the time and the count still describe the same set of pulses.

The timestamp register is not written by the first pulse after reset. That pulse only sets up the reference. Every later pulse writes its arrival time. The two held values are also presented together as one packed field, with the time in the upper half.

Top module: `pulse_pair_capture`

## Requirements
- R1: After reset, `countOut`, `timeOut` and `speedField` are all zero, and the next falling edge is treated as a reference pulse.
- R2: The internal timebase advances by one every `DIVIDE` clocks (default 48), counting from the first clock after reset. It wraps modulo 2^`TIME_W` without saturating. A pulse whose falling input level is first sampled at clock n after reset is stamped with floor((n+1)/`DIVIDE`) mod 2^`TIME_W`.
- R3: The pulse input passes through a two-flop synchronizer. Each high-to-low transition adds exactly one to the live count, and low-to-high transitions add nothing.
- R4: In the cycle after `readStb` is high, `countOut` shows the number of pulses counted since the previous read, and `timeOut` shows the timestamp register as it stood at the read. Both outputs hold their values in every cycle without a read.
- R5: A read clears the live count. A pulse detected in the same cycle as the read is left out of that read's count and counted into the next interval.
- R6: The timestamp register changes only when a pulse is detected, and only from the second pulse after reset onward. The first pulse leaves it at zero.
- R7: When pulses stop, each further read returns a count of zero and the unchanged timestamp of the last pulse.
- R8: `speedField` carries `timeOut` in its upper `TIME_W` bits and `countOut` in its lower `COUNT_W` bits.
- R9: The live pulse count wraps modulo 2^`COUNT_W` without saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Asynchronous wheel-speed pulse, active on its falling edge |
| readStb | input | 1 | One-cycle request to capture the count/time pair |
| countOut | output | COUNT_W | Pulses counted in the last completed interval |
| timeOut | output | TIME_W | Timebase value at the last non-reference pulse of that interval |
| speedField | output | TIME_W+COUNT_W | Time in the upper bits, count in the lower bits |

## Verification
The bench builds the block with `DIVIDE` = 6, `TIME_W` = 8 and `COUNT_W` = 8. With these values, timebase wraparound is reached after about 1,536 clocks and pulse-count wraparound after 256 pulses, so both wraps are exercised well inside the run length. The small divider also makes each pulse timestamp land on an exact, hand-computable timebase value. This is what lets the bench test the case where a read and a pulse meet in the same cycle, and the way the first pulse only sets the reference.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

  // Strobes from control to datapath, one clock cycle each
  typedef struct packed {
    logic tbTick;     // advance the timebase
    logic cntInc;     // a pulse edge was detected
    logic cntClear;   // start a new counting interval
    logic stampLoad;  // record the timebase as the last pulse time
    logic holdLoad;   // copy count and stamp into the holding pair
  } ctrl_strobes_t;

endpackage

// File: rtl/ppc_sync.sv
module ppc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pulseIn,
  output logic fallEdge
);

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], pulseIn};
  end

  assign fallEdge = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/ppc_ctrl.sv
module ppc_ctrl
  import ppc_pkg::*;
#(
  parameter int DIVIDE = 48
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           fallEdge,
  input  logic           readStb,
  output ctrl_strobes_t  strb
);

  localparam int PW = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIVIDE - 1);

  logic [PW-1:0] prescale;
  logic          armed;
  logic          tick;

  assign tick = (prescale == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescale <= '0;
      armed    <= 1'b0;
    end else begin
      prescale <= tick ? '0 : prescale + PW'(1);
      if (fallEdge) armed <= 1'b1;
    end
  end

  always_comb begin
    strb.tbTick    = tick;
    strb.cntInc    = fallEdge;
    strb.cntClear  = readStb;
    strb.stampLoad = fallEdge & armed;
    strb.holdLoad  = readStb;
  end

endmodule

// File: rtl/ppc_dpath.sv
module ppc_dpath
  import ppc_pkg::*;
#(
  parameter int TIME_W  = 16,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobes_t      strb,
  output logic [TIME_W-1:0]  timebase,
  output logic [TIME_W-1:0]  edgeStamp,
  output logic [COUNT_W-1:0] liveCount,
  output logic [TIME_W-1:0]  timeHold,
  output logic [COUNT_W-1:0] countHold
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timebase  <= '0;
      edgeStamp <= '0;
      liveCount <= '0;
      timeHold  <= '0;
      countHold <= '0;
    end else begin
      if (strb.tbTick) timebase <= timebase + TIME_W'(1);

      // a pulse that meets a read opens the next interval
      if (strb.cntClear)    liveCount <= strb.cntInc ? COUNT_W'(1) : '0;
      else if (strb.cntInc) liveCount <= liveCount + COUNT_W'(1);

      if (strb.stampLoad) edgeStamp <= timebase;

      if (strb.holdLoad) begin
        countHold <= liveCount;
        timeHold  <= edgeStamp;
      end
    end
  end

endmodule

// File: rtl/pulse_pair_capture.sv
module pulse_pair_capture
  import ppc_pkg::*;
#(
  parameter int DIVIDE      = 48,
  parameter int TIME_W      = 16,
  parameter int COUNT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pulseIn,
  input  logic                        readStb,
  output logic [COUNT_W-1:0]          countOut,
  output logic [TIME_W-1:0]           timeOut,
  output logic [TIME_W+COUNT_W-1:0]   speedField
);

  ctrl_strobes_t       strb;
  logic                fallEdge;
  logic [TIME_W-1:0]   timebase;
  logic [TIME_W-1:0]   edgeStamp;
  logic [COUNT_W-1:0]  liveCount;

  ppc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .fallEdge(fallEdge)
  );

  ppc_ctrl #(.DIVIDE(DIVIDE)) i_ctrl (
    .clk(clk), .rstN(rstN), .fallEdge(fallEdge), .readStb(readStb), .strb(strb)
  );

  ppc_dpath #(.TIME_W(TIME_W), .COUNT_W(COUNT_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .timebase(timebase), .edgeStamp(edgeStamp), .liveCount(liveCount),
    .timeHold(timeOut), .countHold(countOut)
  );

  assign speedField = {timeOut, countOut};

endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
  parameter int DIVIDE  = 48,
  parameter int TIME_W  = 16,
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               readStb,
  input logic               fallEdge,
  input logic [TIME_W-1:0]  timebase,
  input logic [TIME_W-1:0]  edgeStamp,
  input logic [COUNT_W-1:0] liveCount,
  input logic [COUNT_W-1:0] countOut,
  input logic [TIME_W-1:0]  timeOut
);

  logic [31:0] cyc;
  logic        seenEdge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cyc      <= '0;
      seenEdge <= 1'b0;
    end else begin
      cyc <= cyc + 32'd1;
      if (fallEdge) seenEdge <= 1'b1;
    end
  end

  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    (timebase != $past(timebase)) |-> (cyc % DIVIDE == 0));

  p_tick_due_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cyc != 0 && cyc % DIVIDE == 0) |-> (timebase != $past(timebase)));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!readStb && fallEdge) |=> (liveCount == COUNT_W'($past(liveCount) + 1'b1)));

  p_count_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!readStb && !fallEdge) |=> $stable(liveCount));

  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    !readStb |=> ($stable(countOut) && $stable(timeOut)));

  p_pair_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
    readStb |=> (timeOut == $past(edgeStamp) && countOut == $past(liveCount)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (readStb && !fallEdge) |=> (liveCount == '0));

  p_carry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (readStb && fallEdge) |=> (liveCount == COUNT_W'(1)));

  p_stamp_on_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    (edgeStamp != $past(edgeStamp)) |-> $past(fallEdge));

  p_first_ref_r6: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge && !seenEdge) |=> $stable(edgeStamp));

endmodule

bind pulse_pair_capture ppc_checker #(
  .DIVIDE(DIVIDE), .TIME_W(TIME_W), .COUNT_W(COUNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .readStb(readStb), .fallEdge(fallEdge),
  .timebase(timebase), .edgeStamp(edgeStamp), .liveCount(liveCount),
  .countOut(countOut), .timeOut(timeOut)
);

// File: tb/test_pulse_pair_capture.sv
module test_pulse_pair_capture;

  localparam int DIV = 6;
  localparam int TW  = 8;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pulseIn = 1'b1;
  logic readStb = 1'b0;
  logic [CW-1:0]    countOut;
  logic [TW-1:0]    timeOut;
  logic [TW+CW-1:0] speedField;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // bench model
  int  expCount = 0;
  int  expStamp = 0;
  bit  armed = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  pulse_pair_capture #(.DIVIDE(DIV), .TIME_W(TW), .COUNT_W(CW)) i_pulse_pair_capture (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .readStb(readStb),
    .countOut(countOut), .timeOut(timeOut), .speedField(speedField)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // stamp of a pulse whose low level is driven before posedge n0+1
  function automatic int stampFor(input int n0);
    return ((n0 + 2) / DIV) % (1 << TW);
  endfunction

  function automatic void modelPulse(input int n0);
    if (armed) expStamp = stampFor(n0);
    armed = 1'b1;
    expCount = (expCount + 1) % (1 << CW);
  endfunction

  task automatic doPulse(input int lowC, input int highC);
    @(negedge clk);
    pulseIn = 1'b0;
    modelPulse(cyc);
    repeat (lowC) @(negedge clk);
    pulseIn = 1'b1;
    repeat (highC) @(negedge clk);
  endtask

  task automatic doRead(input string tag);
    @(negedge clk);
    readStb = 1'b1;
    @(negedge clk);
    readStb = 1'b0;
    check(int'(countOut) == expCount, {tag, " count"}, int'(countOut), expCount);
    check(int'(timeOut) == expStamp, {tag, " time"}, int'(timeOut), expStamp);
    expCount = 0;
  endtask

  task automatic t_reset;
    check(countOut == '0, "R1 count at reset", int'(countOut), 0);
    check(timeOut == '0, "R1 time at reset", int'(timeOut), 0);
    check(speedField == '0, "R1 field at reset", int'(speedField), 0);
  endtask

  task automatic t_first_pulse;
    repeat (10) @(negedge clk);
    doPulse(2, 4);
    doRead("R6 first pulse is reference");   // count 1, time stays 0
    repeat (17) @(negedge clk);
    doPulse(3, 5);
    doRead("R2 R6 second pulse stamped");
  endtask

  task automatic t_burst;
    doPulse(1, 2);
    doPulse(20, 7);    // long low: the rising edge adds nothing (R3)
    doPulse(2, 11);
    doPulse(4, 3);
    doPulse(1, 9);
    doRead("R3 R4 burst of five");
    check(speedField == {timeOut, countOut}, "R8 packed field",
          int'(speedField), int'({timeOut, countOut}));
    check(int'(speedField[TW+CW-1:CW]) == expStamp, "R8 time in upper half",
          int'(speedField[TW+CW-1:CW]), expStamp);
  endtask

  task automatic t_hold;
    logic [CW-1:0] c0;
    logic [TW-1:0] t0;
    c0 = countOut;
    t0 = timeOut;
    doPulse(2, 3);
    doPulse(2, 13);
    check(countOut == c0, "R4 count held without read", int'(countOut), int'(c0));
    check(timeOut == t0, "R4 time held without read", int'(timeOut), int'(t0));
    doRead("R4 read after hold");
  endtask

  task automatic t_stop;
    int lastStamp;
    doPulse(2, 4);
    lastStamp = expStamp;
    doRead("R7 before stop");
    repeat (50) @(negedge clk);
    doRead("R7 stopped read one");
    check(int'(timeOut) == lastStamp, "R7 stamp kept", int'(timeOut), lastStamp);
    repeat (23) @(negedge clk);
    doRead("R7 stopped read two");
  endtask

  task automatic t_coincide;
    int n0;
    int oldCount;
    int oldStamp;
    doPulse(2, 5);
    oldCount = expCount;
    oldStamp = expStamp;
    @(negedge clk);
    pulseIn = 1'b0;
    n0 = cyc;
    @(negedge clk);
    @(negedge clk);          // cyc == n0+2: read lands on the detection cycle
    readStb = 1'b1;
    @(negedge clk);
    readStb = 1'b0;
    pulseIn = 1'b1;
    check(int'(countOut) == oldCount, "R5 coincident pulse excluded", int'(countOut), oldCount);
    check(int'(timeOut) == oldStamp, "R5 stamp before coincident pulse", int'(timeOut), oldStamp);
    expCount = 0;
    modelPulse(n0);
    repeat (6) @(negedge clk);
    doRead("R5 coincident pulse in next interval");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 260; i++) doPulse(1, 2);
    doRead("R9 count wraps");
    while (((cyc + 2) / DIV) < 300) @(negedge clk);
    doPulse(2, 4);
    doRead("R2 timebase wraps");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_pulse();
    t_burst();
    t_hold();
    t_stop();
    t_coincide();
    t_wrap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule